// File: doc/BRIEF.md
# Memory Bus Self-Test Engine

This block is a hardware self-test sequencer for an external RAM reached through a simple request port. The port carries an address, write data, a write strobe and a request strobe, and it returns read data with a valid strobe. A start pulse makes the engine work through up to four phases in a fixed order:

- **Data-bus phase:** a walking single set bit is written to address zero at full width.
- **Address-bus phase:** the byte 0xAA is written to each power-of-two byte offset.
- **Aliasing phase:** the byte 0x55 goes to offset zero, and the engine confirms that no power-of-two offset was disturbed.
- **Exhaustive phase (optional):** the whole array is filled with an alternating byte pattern and then all of it is read back.

The engine stops at the first mismatch. It then reports the failing byte address, the value it expected and the value it read.

States, in `bist_pkg`:
- IDLE waits for start.
- DB_WR, DB_RD and DB_WAIT form the data-bus phase.
- AB_WR, AB_RD and AB_WAIT form the address-bus phase.
- AL_WR, AL_RD and AL_WAIT form the aliasing phase.
- EX_WR, EX_RD and EX_WAIT form the exhaustive phase.
- DONE lasts one cycle and returns to IDLE.

Transitions:
- IDLE goes to DB_WR on start.
- Each *_WR state goes to the matching *_RD state. The one exception is EX_WR, which repeats until the last byte is written and then goes to EX_RD.
- Each *_RD state goes to its *_WAIT state.
- A *_WAIT state leaves only on read-valid. On a mismatch it goes to DONE. On a match it goes to the next item of its phase, or to the first state of the next phase.
- AL_WAIT on its last match goes to EX_WR if the latched exhaustive flag is set, and to DONE otherwise.
- EX_WAIT on its last match goes to DONE.

Top module: `mem_bist`

## Requirements
- R1: After reset, busy, done and mem_req are low. A start pulse while idle raises busy on the next cycle. Busy stays high until the cycle in which done is high. A start pulse while busy has no effect on the sequence or on the latched exhaustive flag.
- R2: The data-bus phase does one wide access per step, with mem_wide=1 covering DATA_W/8 bytes little-endian at byte address 0. For i = 0 to DATA_W-1 it writes the value 1<<i and then reads it back before the next step. A wrong read ends the run with fail_addr=0, fail_exp=1<<i and fail_got equal to the read word.
- R3: The address-bus phase does one-byte accesses (mem_wide=0, data in bits 7:0). For each offset 1, 2, 4 up to MEM_BYTES/2, in ascending order, it writes 0xAA and reads that offset back before moving on.
- R4: The aliasing phase writes 0x55 to offset 0. It then reads every power-of-two offset in ascending order and expects 0xAA at each.
- R5: The exhaustive input is sampled on the accepted start. When it is 0, the run ends after the aliasing phase, with DATA_W+ADDR_W+1 writes and DATA_W+2*ADDR_W reads in total.
- R6: When exhaustive is sampled as 1, the engine writes every byte in ascending order (0x55 at even offsets, 0xAA at odd offsets). No read is issued until the last of these writes. It then reads and compares every byte in ascending order. A passing run adds MEM_BYTES writes and MEM_BYTES reads.
- R7: The first mismatch ends the run. No further memory request follows. Done is raised with pass=0, and the failing byte address, expected value and observed value are reported. In byte phases, fail_got is bits 7:0 of the read data, zero-extended.
- R8: At most one read is outstanding. After a read request the engine issues no request and does no compare until mem_rvalid, whatever the latency.
- R9: Done is high for exactly one cycle. Pass and the failure fields are cleared on an accepted start and then hold their final values until the next accepted start. A passing run leaves the failure fields at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| exhaustive | input | 1 | Enable the full-array phase, sampled at launch |
| mem_req | output | 1 | Memory request strobe, one cycle per access |
| mem_we | output | 1 | 1 = write, 0 = read, valid with mem_req |
| mem_wide | output | 1 | 1 = full DATA_W access, 0 = byte access on bits 7:0 |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Run completed without mismatch |
| fail_addr | output | ADDR_W | Byte address of the first mismatch |
| fail_exp | output | DATA_W | Expected value at the first mismatch |
| fail_got | output | DATA_W | Observed value at the first mismatch |

## Verification
The bench runs against a byte-array model that can inject faults. It targets a stuck data bit at both the lowest and the highest positions that fail. A design that walked too few bits would pass the top-bit fault. It also targets a shorted address line, which passes the address phase but must be caught by the aliasing read. A design that skipped aliasing, or read before writing 0x55 to offset zero, would report pass. Single dead cells are placed inside the address phase, and at odd and even offsets reached only by the exhaustive pass. Here the exact read and write counts show whether the engine stopped at the first mismatch and whether the exhaustive input was honoured. Variable read latency and a start pulse injected mid-run expose designs that compare before read-valid or re-launch while busy.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DB_WR, ST_DB_RD, ST_DB_WAIT,
        ST_AB_WR, ST_AB_RD, ST_AB_WAIT,
        ST_AL_WR, ST_AL_RD, ST_AL_WAIT,
        ST_EX_WR, ST_EX_RD, ST_EX_WAIT,
        ST_DONE
    } bist_state_e;

    localparam logic [7:0] PAT_MARK = 8'hAA;
    localparam logic [7:0] PAT_ANTI = 8'h55;
endpackage

// File: rtl/bist_fsm.sv
module bist_fsm
    import bist_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exhaustive,
    input  logic              rd_valid,
    input  logic              mismatch,
    output bist_state_e       state,
    output logic [ADDR_W-1:0] cur,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              launch
);
    bist_state_e state_nx;
    logic        ex_q;
    logic        last_bit, last_pow, last_all, ok, bad;

    assign last_bit = (bit_idx == BIT_W'(DATA_W - 1));
    assign last_pow = cur[ADDR_W-1];
    assign last_all = &cur;
    assign ok       = rd_valid && !mismatch;
    assign bad      = rd_valid && mismatch;
    assign launch   = (state == ST_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_DB_WR;
            ST_DB_WR:   state_nx = ST_DB_RD;
            ST_DB_RD:   state_nx = ST_DB_WAIT;
            ST_DB_WAIT: if (bad) state_nx = ST_DONE;
                        else if (ok) state_nx = last_bit ? ST_AB_WR : ST_DB_WR;
            ST_AB_WR:   state_nx = ST_AB_RD;
            ST_AB_RD:   state_nx = ST_AB_WAIT;
            ST_AB_WAIT: if (bad) state_nx = ST_DONE;
                        else if (ok) state_nx = last_pow ? ST_AL_WR : ST_AB_WR;
            ST_AL_WR:   state_nx = ST_AL_RD;
            ST_AL_RD:   state_nx = ST_AL_WAIT;
            ST_AL_WAIT: if (bad) state_nx = ST_DONE;
                        else if (ok) begin
                            if (!last_pow)  state_nx = ST_AL_RD;
                            else if (ex_q)  state_nx = ST_EX_WR;
                            else            state_nx = ST_DONE;
                        end
            ST_EX_WR:   if (last_all) state_nx = ST_EX_RD;
            ST_EX_RD:   state_nx = ST_EX_WAIT;
            ST_EX_WAIT: if (bad) state_nx = ST_DONE;
                        else if (ok) state_nx = last_all ? ST_DONE : ST_EX_RD;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Cursor, bit index and latched mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            bit_idx <= '0;
            ex_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    bit_idx <= '0;
                    cur     <= '0;
                    ex_q    <= exhaustive;
                end
                ST_DB_WAIT: if (ok) begin
                    if (last_bit) cur <= ADDR_W'(1);
                    else          bit_idx <= bit_idx + BIT_W'(1);
                end
                ST_AB_WAIT: if (ok && !last_pow) cur <= cur << 1;
                ST_AL_WR:   cur <= ADDR_W'(1);
                ST_AL_WAIT: if (ok) cur <= last_pow ? '0 : (cur << 1);
                ST_EX_WR:   cur <= last_all ? '0 : (cur + ADDR_W'(1));
                ST_EX_WAIT: if (ok) cur <= cur + ADDR_W'(1);
                default: ;
            endcase
        end
    end

    // R1: a start while busy must not re-launch the sequence
    p_launch_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_DB_WR) || $past(state == ST_DB_WAIT));
endmodule

// File: rtl/bist_datapath.sv
module bist_datapath
    import bist_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  bist_state_e       state,
    input  logic [ADDR_W-1:0] cur,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] rdata,
    output logic              req,
    output logic              we,
    output logic              wide,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] exp_val,
    output logic [DATA_W-1:0] got_val,
    output logic              mismatch
);
    logic [DATA_W-1:0] walk_val, alt_val;

    assign walk_val = DATA_W'(1) << bit_idx;
    assign alt_val  = DATA_W'(cur[0] ? PAT_MARK : PAT_ANTI);

    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        wide    = 1'b0;
        addr    = cur;
        wdata   = '0;
        exp_val = '0;
        unique case (state)
            ST_DB_WR:   begin req = 1'b1; we = 1'b1; wide = 1'b1; addr = '0; wdata = walk_val; end
            ST_DB_RD:   begin req = 1'b1; wide = 1'b1; addr = '0; end
            ST_DB_WAIT: begin wide = 1'b1; addr = '0; exp_val = walk_val; end
            ST_AB_WR:   begin req = 1'b1; we = 1'b1; wdata = DATA_W'(PAT_MARK); end
            ST_AB_RD:   req = 1'b1;
            ST_AB_WAIT: exp_val = DATA_W'(PAT_MARK);
            ST_AL_WR:   begin req = 1'b1; we = 1'b1; addr = '0; wdata = DATA_W'(PAT_ANTI); end
            ST_AL_RD:   req = 1'b1;
            ST_AL_WAIT: exp_val = DATA_W'(PAT_MARK);
            ST_EX_WR:   begin req = 1'b1; we = 1'b1; wdata = alt_val; end
            ST_EX_RD:   req = 1'b1;
            ST_EX_WAIT: exp_val = alt_val;
            default: ;
        endcase
    end

    assign got_val  = wide ? rdata : DATA_W'(rdata[7:0]);
    assign mismatch = (got_val != exp_val);
endmodule

// File: rtl/bist_result.sv
module bist_result
    import bist_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bist_state_e       state,
    input  logic              launch,
    input  logic              rd_valid,
    input  logic              mismatch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] exp_val,
    input  logic [DATA_W-1:0] got_val,
    input  logic              start,
    input  logic              busy,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    logic in_wait, failed_q, fin_q;

    always_comb begin
        unique case (state)
            ST_DB_WAIT, ST_AB_WAIT, ST_AL_WAIT, ST_EX_WAIT: in_wait = 1'b1;
            default: in_wait = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            failed_q  <= 1'b0;
            fin_q     <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else if (launch) begin
            failed_q  <= 1'b0;
            fin_q     <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else begin
            if (in_wait && rd_valid && mismatch) begin
                failed_q  <= 1'b1;
                fail_addr <= addr;
                fail_exp  <= exp_val;
                fail_got  <= got_val;
            end
            if (state == ST_DONE) fin_q <= 1'b1;
        end
    end

    assign pass = (fin_q || state == ST_DONE) && !failed_q;

    // R9: results hold while idle and no start arrives
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && state != ST_DONE) |=> $stable(fail_addr) && $stable(pass));
endmodule

// File: rtl/mem_bist.sv
module mem_bist
    import bist_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_BYTES = 65536,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int BIT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              exhaustive,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);
    generate
        if (DATA_W < 8 || (DATA_W % 8) != 0 || MEM_BYTES < 2 ||
            (MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_cfg
            initial $error("mem_bist: DATA_W must be a multiple of 8, MEM_BYTES a power of two >= 2");
        end
    endgenerate

    bist_state_e       state;
    logic [ADDR_W-1:0] cur;
    logic [BIT_W-1:0]  bit_idx;
    logic              launch, mismatch;
    logic [DATA_W-1:0] exp_val, got_val;

    bist_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .exhaustive(exhaustive),
        .rd_valid(mem_rvalid), .mismatch(mismatch),
        .state(state), .cur(cur), .bit_idx(bit_idx), .launch(launch)
    );

    bist_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
        .state(state), .cur(cur), .bit_idx(bit_idx), .rdata(mem_rdata),
        .req(mem_req), .we(mem_we), .wide(mem_wide), .addr(mem_addr),
        .wdata(mem_wdata), .exp_val(exp_val), .got_val(got_val), .mismatch(mismatch)
    );

    always_comb begin
        busy = (state != ST_IDLE) && (state != ST_DONE);
        done = (state == ST_DONE);
    end

    bist_result #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_res (
        .clk(clk), .rst_n(rst_n), .state(state), .launch(launch),
        .rd_valid(mem_rvalid), .mismatch(mismatch), .addr(mem_addr),
        .exp_val(exp_val), .got_val(got_val), .start(start), .busy(busy),
        .pass(pass), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    // R1: busy only falls into the done cycle
    p_busy_ends_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R1: busy only rises after a start pulse
    p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R8: nothing is requested in the cycle after a read request
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a failed run issues no request in its done cycle
    p_stop_on_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> !mem_req);
endmodule

// File: tb/mem_bist_bench.sv
`timescale 1ns/1ps
module mem_bist_bench;
    localparam int DW = 16;
    localparam int MB = 64;
    localparam int AW = 6;
    localparam int BASE_W = DW + AW + 1;   // 23
    localparam int BASE_R = DW + 2 * AW;   // 28

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic exhaustive = 1'b0;
    logic mem_req, mem_we, mem_wide, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_got;

    always #5 clk = ~clk;

    mem_bist #(.DATA_W(DW), .MEM_BYTES(MB)) u_mem_bist (
        .clk(clk), .rst_n(rst_n), .start(start), .exhaustive(exhaustive),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    // Fault configuration
    logic [DW-1:0] stuck_mask = '0;
    logic [AW-1:0] alias_mask = '0;
    logic          cell_en = 1'b0;
    logic [AW-1:0] cell_addr = '0;
    logic          var_lat = 1'b0;
    logic          clr = 1'b0;

    logic [7:0] mem [MB];
    int wcnt, rcnt, rd_at_lw, done_cnt;
    int pend;
    logic [DW-1:0] pend_data;
    logic [1:0] lat_ctr;

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] rd_byte(input logic [AW-1:0] a);
        logic [AW-1:0] e;
        e = a & ~alias_mask;
        if (cell_en && e == cell_addr) return 8'h00;
        return mem[e];
    endfunction

    function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a, input logic w);
        logic [DW-1:0] d;
        d = '0;
        if (w) begin
            for (int b = 0; b < DW / 8; b++) d[b*8 +: 8] = rd_byte(a + AW'(b));
        end else begin
            d = DW'(rd_byte(a));
        end
        return d & ~stuck_mask;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (clr) begin
            wcnt <= 0; rcnt <= 0; rd_at_lw <= 0; done_cnt <= 0; pend <= 0;
            for (int i = 0; i < MB; i++) mem[i] <= 8'h00;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            lat_ctr <= lat_ctr + 2'd1;
            if (mem_req && mem_we) begin
                wcnt <= wcnt + 1;
                rd_at_lw <= rcnt;
                if (mem_wide) begin
                    for (int b = 0; b < DW / 8; b++)
                        mem[(mem_addr + AW'(b)) & ~alias_mask] <= mem_wdata[b*8 +: 8];
                end else begin
                    mem[mem_addr & ~alias_mask] <= mem_wdata[7:0];
                end
            end else if (mem_req) begin
                rcnt <= rcnt + 1;
                pend_data <= rd_word(mem_addr, mem_wide);
                pend <= var_lat ? (int'(lat_ctr % 3) + 1) : 1;
            end else if (pend == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata <= pend_data;
                pend <= 0;
            end else if (pend > 1) begin
                pend <= pend - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic run(input logic ex, input bit mid_start, input bit exp_pass,
                       input int e_addr, input int e_exp, input int e_got,
                       input int e_w, input int e_r, input string tag);
        int n;
        bit seen;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        start = 1'b1; exhaustive = ex;
        @(negedge clk); start = 1'b0; exhaustive = 1'b0;
        chk(busy === 1'b1, {tag, " R1 busy after start"}, int'(busy), 1);
        seen = 1'b0;
        n = 0;
        while (!seen && n < 20000) begin
            if (mid_start && n == 10) begin start = 1'b1; exhaustive = ~ex; end
            if (mid_start && n == 11) begin start = 1'b0; exhaustive = 1'b0; end
            @(negedge clk);
            n++;
            if (done) seen = 1'b1;
        end
        chk(seen, {tag, " done reached"}, int'(seen), 1);
        chk(pass === exp_pass, {tag, " pass"}, int'(pass), int'(exp_pass));
        chk(int'(fail_addr) == e_addr, {tag, " fail_addr"}, int'(fail_addr), e_addr);
        chk(int'(fail_exp) == e_exp, {tag, " fail_exp"}, int'(fail_exp), e_exp);
        chk(int'(fail_got) == e_got, {tag, " fail_got"}, int'(fail_got), e_got);
        repeat (4) @(negedge clk);
        chk(wcnt == e_w, {tag, " R7 write count"}, wcnt, e_w);
        chk(rcnt == e_r, {tag, " R7 read count"}, rcnt, e_r);
        chk(done_cnt == 1, {tag, " R9 single done"}, done_cnt, 1);
        chk(busy === 1'b0, {tag, " R1 idle after done"}, int'(busy), 0);
        chk(pass === exp_pass, {tag, " R9 pass held"}, int'(pass), int'(exp_pass));
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        lat_ctr = 2'd0;
        mem_rvalid = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        chk(mem_req === 1'b0, "R1 reset mem_req", int'(mem_req), 0);
        rst_n = 1'b1;

        // R5: clean memory, short run
        run(1'b0, 1'b0, 1'b1, 0, 0, 0, BASE_W, BASE_R, "R5 clean short");
        // R6: clean memory, exhaustive with variable latency (R8)
        var_lat = 1'b1;
        run(1'b1, 1'b0, 1'b1, 0, 0, 0, BASE_W + MB, BASE_R + MB, "R6 R8 clean full");
        chk(rd_at_lw == BASE_R, "R6 no read before last fill write", rd_at_lw, BASE_R);
        // R1: start while busy (with flipped exhaustive) ignored
        run(1'b0, 1'b1, 1'b1, 0, 0, 0, BASE_W, BASE_R, "R1 start while busy");
        // R2: stuck data bit 5 and bit 15
        stuck_mask = 16'h0020;
        run(1'b0, 1'b0, 1'b0, 0, 16'h0020, 16'h0000, 6, 6, "R2 stuck bit5");
        stuck_mask = 16'h8000;
        run(1'b1, 1'b0, 1'b0, 0, 16'h8000, 16'h0000, 16, 16, "R2 stuck bit15");
        stuck_mask = '0;
        // R4: address line 3 ignored, caught by aliasing at offset 8
        alias_mask = 6'd8;
        run(1'b0, 1'b0, 1'b0, 8, 8'hAA, 8'h55, BASE_W, DW + AW + 4, "R4 alias a3");
        alias_mask = '0;
        // R3: dead cell at 16 caught in address phase
        cell_en = 1'b1; cell_addr = 6'd16;
        run(1'b0, 1'b0, 1'b0, 16, 8'hAA, 8'h00, DW + 5, DW + 5, "R3 dead cell 16");
        // R5: dead cell 37 unseen without exhaustive
        cell_addr = 6'd37;
        run(1'b0, 1'b0, 1'b1, 0, 0, 0, BASE_W, BASE_R, "R5 dead cell 37 short");
        // R6/R7: caught by exhaustive at odd and even offsets
        run(1'b1, 1'b0, 1'b0, 37, 8'hAA, 8'h00, BASE_W + MB, BASE_R + 38, "R6 R7 dead cell 37");
        cell_addr = 6'd36;
        run(1'b1, 1'b0, 1'b0, 36, 8'h55, 8'h00, BASE_W + MB, BASE_R + 37, "R6 R7 dead cell 36");
        cell_en = 1'b0;
        // R9: a passing run after a failure clears the fields
        run(1'b0, 1'b0, 1'b1, 0, 0, 0, BASE_W, BASE_R, "R9 clean after fail");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule